// File: doc/BRIEF.md
# Function-Coded Integer Arithmetic and Logic Unit

This block is the purely combinational arithmetic and logic stage of a simple single-issue datapath. It takes two 32-bit operands and a 5-bit shift distance. A 6-bit function selector picks one of nine operations: add, subtract, multiply, divide, AND, OR, logical shift right, shift left and one's complement. The shift distance comes from a dedicated instruction field, and both shifts act on the second operand.

A one-bit enable chooses between two modes. When it is high, the function selector decides the operation. When it is low, the unit adds the two operands whatever the selector holds; this serves address generation and immediate additions. Apart from its result, the unit produces nothing: no flags, no condition codes and no exceptions.

Two cases are defined by convention. Division by zero returns a word of all ones. A selector value that names no operation returns zero.

Top module: `fcode_alu`

## Requirements
- R1: When `fn_enable` is 0, `result` equals `a_in + b_in` modulo 2^32, for every value of `fn_code`.
- R2: With `fn_enable` = 1, code 6'b100000 gives `a_in + b_in` and code 6'b100010 gives `a_in - b_in`, both modulo 2^32.
- R3: Code 6'b011000 gives the low 32 bits of the two's-complement product of `a_in` and `b_in`.
- R4: Code 6'b011011 gives the signed quotient `a_in / b_in`, truncated toward zero; the quotient of 32'h80000000 by 32'hFFFFFFFF is 32'h80000000.
- R5: Code 6'b011011 with `b_in` = 0 gives 32'hFFFFFFFF.
- R6: Code 6'b001101 gives `a_in & b_in`, and code 6'b001111 gives `a_in | b_in`.
- R7: Code 6'b000011 gives `b_in` shifted right logically (zero fill) by `sh_amt`, and code 6'b000010 gives `b_in` shifted left by `sh_amt`.
- R8: Code 6'b001011 gives `~b_in`; `a_in` has no effect on the result.
- R9: With `fn_enable` = 1, any code other than the nine listed above gives 0.
- R10: `sh_amt` has no effect on the result for any operation except the two shifts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 32 | First operand (dividend, minuend) |
| b_in | input | 32 | Second operand; source for shifts and complement |
| sh_amt | input | 5 | Shift distance for the two shift operations |
| fn_code | input | 6 | Function selector |
| fn_enable | input | 1 | 1: operation chosen by `fn_code`; 0: forced addition |
| result | output | 32 | Operation result |

## Verification
The hardest situations to reach from the ports are the divide corners: a zero divisor, the most negative dividend over minus one, and mixed-sign quotients that must truncate toward zero. Random operands almost never produce these. The bench therefore crosses a fixed set of corner words (0, 1, all ones, the most negative and most positive values, and small signed values) over all 64 selector values in both enable states, with the shift distance varying along the sweep. Random vectors then cover the bulk of the operand space.

// File: rtl/fcode_alu_pkg.sv
package fcode_alu_pkg;

    localparam int FN_W = 6;

    typedef enum logic [FN_W-1:0] {
        FN_SLL  = 6'b000010,
        FN_SRL  = 6'b000011,
        FN_CMPL = 6'b001011,
        FN_AND  = 6'b001101,
        FN_OR   = 6'b001111,
        FN_MUL  = 6'b011000,
        FN_DIV  = 6'b011011,
        FN_ADD  = 6'b100000,
        FN_SUB  = 6'b100010
    } fn_e;

    function automatic logic fn_known(input logic [FN_W-1:0] code);
        case (code)
            FN_SLL, FN_SRL, FN_CMPL, FN_AND, FN_OR,
            FN_MUL, FN_DIV, FN_ADD, FN_SUB: fn_known = 1'b1;
            default:                        fn_known = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/fcode_alu_addsub.sv
module fcode_alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         do_sub,
    output logic [W-1:0] sum
);
    logic [W-1:0] b_eff;

    // subtraction as a + ~b + 1 on a single carry chain
    always_comb begin
        b_eff = do_sub ? ~b : b;
        sum   = a + b_eff + {{(W-1){1'b0}}, do_sub};
    end
endmodule

// File: rtl/fcode_alu_muldiv.sv
module fcode_alu_muldiv #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] prod,
    output logic [W-1:0] quot
);
    logic         neg_a, neg_b, b_zero;
    logic [W-1:0] mag_a, mag_b, divisor, mag_q;

    // low half of a product does not depend on signedness
    always_comb prod = a * b;

    // signed divide via magnitudes; most-negative / -1 wraps naturally
    always_comb begin
        neg_a   = a[W-1];
        neg_b   = b[W-1];
        b_zero  = (b == '0);
        mag_a   = neg_a ? (~a + 1'b1) : a;
        mag_b   = neg_b ? (~b + 1'b1) : b;
        divisor = b_zero ? {{(W-1){1'b0}}, 1'b1} : mag_b;
        mag_q   = mag_a / divisor;
        if (b_zero)
            quot = '1;
        else if (neg_a ^ neg_b)
            quot = ~mag_q + 1'b1;
        else
            quot = mag_q;
    end
endmodule

// File: rtl/fcode_alu_bitops.sv
module fcode_alu_bitops
    import fcode_alu_pkg::*;
#(
    parameter int W  = 32,
    parameter int SW = 5
) (
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic [SW-1:0]   sh,
    input  logic [FN_W-1:0] code,
    output logic [W-1:0]    y
);
    always_comb begin
        case (code)
            FN_AND:  y = a & b;
            FN_OR:   y = a | b;
            FN_SRL:  y = b >> sh;
            FN_SLL:  y = b << sh;
            FN_CMPL: y = ~b;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/fcode_alu.sv
module fcode_alu
    import fcode_alu_pkg::*;
#(
    parameter int W  = 32,
    parameter int SW = 5
) (
    input  logic [W-1:0]    a_in,
    input  logic [W-1:0]    b_in,
    input  logic [SW-1:0]   sh_amt,
    input  logic [FN_W-1:0] fn_code,
    input  logic            fn_enable,
    output logic [W-1:0]    result
);
    logic            sub_sel;
    logic [W-1:0]    sum_w, prod_w, quot_w, bits_w;

    assign sub_sel = fn_enable && (fn_code == FN_SUB);

    fcode_alu_addsub #(.W(W)) u_addsub (
        .a      (a_in),
        .b      (b_in),
        .do_sub (sub_sel),
        .sum    (sum_w)
    );

    fcode_alu_muldiv #(.W(W)) u_muldiv (
        .a    (a_in),
        .b    (b_in),
        .prod (prod_w),
        .quot (quot_w)
    );

    fcode_alu_bitops #(.W(W), .SW(SW)) u_bitops (
        .a    (a_in),
        .b    (b_in),
        .sh   (sh_amt),
        .code (fn_code),
        .y    (bits_w)
    );

    // result select
    always_comb begin
        if (!fn_enable) begin
            result = sum_w;
        end else begin
            unique case (fn_code)
                FN_ADD, FN_SUB:                   result = sum_w;
                FN_MUL:                           result = prod_w;
                FN_DIV:                           result = quot_w;
                FN_AND, FN_OR, FN_SRL, FN_SLL,
                FN_CMPL:                          result = bits_w;
                default:                          result = '0;
            endcase
        end
    end
endmodule

// File: rtl/fcode_alu_chk.sv
module fcode_alu_chk
    import fcode_alu_pkg::*;
#(
    parameter int W  = 32,
    parameter int SW = 5
) (
    input logic [W-1:0]    a_in,
    input logic [W-1:0]    b_in,
    input logic [SW-1:0]   sh_amt,
    input logic [FN_W-1:0] fn_code,
    input logic            fn_enable,
    input logic [W-1:0]    result
);
    always_comb begin
        if (!$isunknown({a_in, b_in, sh_amt, fn_code, fn_enable, result})) begin
            if (!fn_enable)
                a_r1_forced_add: assert (result == a_in + b_in);
            if (fn_enable && fn_code == FN_SUB)
                a_r2_sub_undoes_add: assert (result + b_in == a_in);
            if (fn_enable && fn_code == FN_DIV && b_in == '0)
                a_r5_div_zero_ones: assert (result == '1);
            if (fn_enable && fn_code == FN_AND)
                a_r6_and_within_both: assert (((result & ~a_in) | (result & ~b_in)) == '0);
            if (fn_enable && fn_code == FN_SRL)
                a_r7_srl_zero_fill: assert (result == (b_in >> sh_amt));
            if (fn_enable && fn_code == FN_CMPL)
                a_r8_cmpl_inverts: assert ((result ^ b_in) == '1);
            if (fn_enable && !fn_known(fn_code))
                a_r9_unknown_zero: assert (result == '0);
        end
    end
endmodule

bind fcode_alu fcode_alu_chk #(.W(W), .SW(SW)) u_fcode_alu_chk (
    .a_in      (a_in),
    .b_in      (b_in),
    .sh_amt    (sh_amt),
    .fn_code   (fn_code),
    .fn_enable (fn_enable),
    .result    (result)
);

// File: tb/test_fcode_alu.sv
module test_fcode_alu;

    logic        clk = 1'b0;
    logic [31:0] a_in, b_in;
    logic [4:0]  sh_amt;
    logic [5:0]  fn_code;
    logic        fn_enable;
    logic [31:0] result;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    fcode_alu i_fcode_alu (
        .a_in      (a_in),
        .b_in      (b_in),
        .sh_amt    (sh_amt),
        .fn_code   (fn_code),
        .fn_enable (fn_enable),
        .result    (result)
    );

    function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b,
                                          input logic [4:0] s, input logic [5:0] c,
                                          input logic en);
        logic signed [63:0] p;
        logic signed [31:0] sa, sb;
        sa = a; sb = b;
        if (!en) return a + b;
        case (c)
            6'b100000: return a + b;
            6'b100010: return a - b;
            6'b011000: begin p = 64'(sa) * 64'(sb); return p[31:0]; end
            6'b011011: begin
                if (b == 32'd0) return 32'hFFFF_FFFF;
                if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return 32'h8000_0000;
                return sa / sb;
            end
            6'b001101: return a & b;
            6'b001111: return a | b;
            6'b000011: return b >> s;
            6'b000010: return b << s;
            6'b001011: return ~b;
            default:   return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [5:0] c, input logic en, input logic [31:0] b);
        if (!en) return "R1";
        case (c)
            6'b100000, 6'b100010: return "R2";
            6'b011000:            return "R3";
            6'b011011:            return (b == 32'd0) ? "R5" : "R4";
            6'b001101, 6'b001111: return "R6";
            6'b000011, 6'b000010: return "R7";
            6'b001011:            return "R8";
            default:              return "R9";
        endcase
    endfunction

    task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic [4:0] s,
                         input logic [5:0] c, input logic en);
        @(posedge clk);
        #2;
        a_in = a; b_in = b; sh_amt = s; fn_code = c; fn_enable = en;
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] exp);
        total++;
        if (result !== exp) begin
            bad++;
            $display("FAIL %s: code=%b en=%b a=%h b=%h sh=%0d actual=%h expected=%h",
                     tag, fn_code, fn_enable, a_in, b_in, sh_amt, result, exp);
        end
    endtask

    task automatic run_vec(input logic [31:0] a, input logic [31:0] b, input logic [4:0] s,
                           input logic [5:0] c, input logic en);
        drive(a, b, s, c, en);
        check(tag_of(c, en, b), model(a, b, s, c, en));
    endtask

    logic [31:0] corner [8];
    logic [31:0] keep;

    initial begin
        corner[0] = 32'h0000_0000; corner[1] = 32'h0000_0001;
        corner[2] = 32'hFFFF_FFFF; corner[3] = 32'h8000_0000;
        corner[4] = 32'h7FFF_FFFF; corner[5] = 32'h1234_5678;
        corner[6] = 32'h0000_0007; corner[7] = 32'hFFFF_FFF9;

        // idle state: all inputs zero gives zero (R1 add of zeros)
        drive(32'd0, 32'd0, 5'd0, 6'd0, 1'b0);
        check("R1", 32'd0);

        // directed divide corners
        drive(32'h8000_0000, 32'hFFFF_FFFF, 5'd3, 6'b011011, 1'b1);
        check("R4", 32'h8000_0000);
        drive(32'hFFFF_FFF9, 32'd2, 5'd0, 6'b011011, 1'b1);   // -7/2 = -3
        check("R4", 32'hFFFF_FFFD);
        drive(32'd7, 32'hFFFF_FFFE, 5'd0, 6'b011011, 1'b1);   // 7/-2 = -3
        check("R4", 32'hFFFF_FFFD);
        drive(32'd12345, 32'd0, 5'd0, 6'b011011, 1'b1);
        check("R5", 32'hFFFF_FFFF);
        drive(32'd5, 32'd3, 5'd0, 6'b011000, 1'b1);
        check("R3", 32'd15);
        drive(32'd5, 32'd3, 5'd0, 6'b011011, 1'b0);           // forced add
        check("R1", 32'd8);

        // R10: shift distance ignored outside shifts
        drive(32'h1234_5678, 32'h0F0F_0F0F, 5'd0, 6'b100000, 1'b1);
        keep = result;
        drive(32'h1234_5678, 32'h0F0F_0F0F, 5'd31, 6'b100000, 1'b1);
        check("R10", keep);
        drive(32'hFFFF_FFF9, 32'd3, 5'd0, 6'b011011, 1'b1);
        keep = result;
        drive(32'hFFFF_FFF9, 32'd3, 5'd17, 6'b011011, 1'b1);
        check("R10", keep);

        // R8: first operand ignored by complement
        drive(32'd0, 32'hA5A5_0000, 5'd4, 6'b001011, 1'b1);
        keep = result;
        drive(32'hFFFF_FFFF, 32'hA5A5_0000, 5'd4, 6'b001011, 1'b1);
        check("R8", keep);

        // shift extremes
        drive(32'd0, 32'h8000_0001, 5'd31, 6'b000011, 1'b1);
        check("R7", 32'h0000_0001);
        drive(32'd0, 32'h8000_0001, 5'd31, 6'b000010, 1'b1);
        check("R7", 32'h8000_0000);

        // sweep: every code, both enable states, corner operand pairs
        for (int c = 0; c < 64; c++)
            for (int e = 0; e < 2; e++)
                for (int i = 0; i < 8; i++)
                    for (int j = 0; j < 8; j++)
                        run_vec(corner[i], corner[j], 5'((i + 3 * j + c) % 32), 6'(c), e[0]);

        // random operands over every code
        for (int k = 0; k < 3000; k++)
            run_vec($urandom, $urandom, 5'($urandom), 6'($urandom % 64), ($urandom % 4) != 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule